// File: doc/BRIEF.md
# I2C Bit-Level Primitive Engine

This block owns the two open-drain wires of a single-controller I2C port and executes one bus primitive per request: start condition, repeated start, stop condition, byte transmit, byte receive, acknowledge sampling, and driving an ACK or a NACK bit. A higher-level sequencer issues a primitive and waits for a one-cycle completion pulse. It then reads the sampled acknowledge level or the received byte and issues the next primitive. Between primitives the engine keeps SCL low so that the bus stays owned.

Bus timing comes entirely from three count inputs. The SCL low phase and the SCL high phase are set separately, each lasting count plus one clock cycles, so asymmetric duty cycles such as a 36/64 fast-mode split are possible. A third count sets how long SDA is held after SCL falls before new data is placed on it. Both lines are outputs that enable a low drive: a 1 pulls the wire low and a 0 releases it. A global enable input aborts any primitive in progress and keeps both wires released while it is low.

Top module: `i2c_prim_engine`

## Requirements
- R1: After reset, and while no primitive is running, scl_oe_o and sda_oe_o do not change. Reset leaves both at 0, with busy_o and done_o at 0.
- R2: In every bit slot SCL is driven low for exactly scl_low_cnt_i+1 cycles and then released for exactly scl_high_cnt_i+1 cycles. A one-bit primitive is one slot and a byte primitive is 8 slots.
- R3: Within a slot, sda_oe_o keeps its previous value for the first min(sda_hold_cnt_i, scl_low_cnt_i) cycles of the SCL low phase. It then takes the slot's value, which it keeps through the high phase.
- R4: Byte transmit (op_i=3) sends tx_byte_i most significant bit first. It drives sda_oe_o=1 for a 0 bit and 0 for a 1 bit.
- R5: Byte receive (op_i=4) releases SDA and samples sda_i in cycle floor(scl_high_cnt_i/2) of each high phase, most significant bit first. The received byte is on rx_byte_o during the done_o cycle.
- R6: Acknowledge sampling (op_i=5) releases SDA for one slot and places the sampled level on ack_bit_o, where 0 means acknowledged. Drive ACK (op_i=6) holds SDA low for one slot. Drive NACK (op_i=7) releases SDA for one slot.
- R7: Start (op_i=0) on a free bus (SCL released) pulls SDA low with SCL released for scl_high_cnt_i+1 cycles, then pulls SCL low. If SCL is already held low, start behaves exactly as a repeated start.
- R8: Repeated start (op_i=1) runs one slot with SDA released, then does the start sequence of R7.
- R9: Stop (op_i=2) runs one slot with SDA low. It then releases SDA while SCL is released and waits scl_high_cnt_i+1 cycles before completing, leaving both lines released.
- R10: done_o is a single-cycle pulse that coincides with busy_o falling and with the final line state. req_i is ignored while busy_o is high.
- R11: While enable_i is low, the next cycle has both lines released, busy_o low and no primitive running, and req_i is ignored.
- R12: Every primitive ends in the done_o cycle with SCL low, except stop. The first output change after an accepted request appears in the cycle following the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Global enable; low aborts and releases the bus |
| scl_high_cnt_i | input | CNT_W | SCL high phase length minus one, in cycles |
| scl_low_cnt_i | input | CNT_W | SCL low phase length minus one, in cycles |
| sda_hold_cnt_i | input | HOLD_W | SDA hold delay after SCL falls, in cycles |
| req_i | input | 1 | Request a primitive (accepted when idle and enabled) |
| op_i | input | 3 | Primitive code (see requirements) |
| tx_byte_i | input | BYTE_W | Byte to transmit, captured at acceptance |
| sda_i | input | 1 | Sensed SDA wire level |
| busy_o | output | 1 | Primitive in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_bit_o | output | 1 | Last sampled acknowledge level |
| rx_byte_o | output | BYTE_W | Received byte |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the engine with CNT_W=6, HOLD_W=6 and BYTE_W=8. This keeps every count input small, so it can sweep scl_high_cnt_i from 0 to 4, scl_low_cnt_i from 0 to 4 and sda_hold_cnt_i from 0 to 6 and run a full primitive sequence under each combination. The sweep covers the minimum two-cycle bit period, a midpoint sample that falls on the last high cycle, a hold of zero, and a hold longer than the low phase, where the clamp applies. The responder presents the correct SDA level only in the intended sample cycle, so any drift of the sample point shows up in the received byte and in the acknowledge bit.

// File: rtl/i2c_prim_pkg.sv
package i2c_prim_pkg;

   typedef enum logic [2:0] {
      OP_START   = 3'd0,
      OP_RSTART  = 3'd1,
      OP_STOP    = 3'd2,
      OP_WRBYTE  = 3'd3,
      OP_RDBYTE  = 3'd4,
      OP_GETACK  = 3'd5,
      OP_PUTACK  = 3'd6,
      OP_PUTNACK = 3'd7
   } prim_op_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOW,
      PH_HIGH,
      PH_COND,
      PH_FREE
   } prim_phase_e;

   // Value of the SDA pull-down during a slot of the given primitive.
   function automatic logic slot_drive(prim_op_e op, logic msb);
      case (op)
         OP_WRBYTE: return ~msb;
         OP_PUTACK: return 1'b1;
         OP_STOP:   return 1'b1;
         default:   return 1'b0;
      endcase
   endfunction

   function automatic logic is_byte_op(prim_op_e op);
      return (op == OP_WRBYTE) || (op == OP_RDBYTE);
   endfunction

endpackage

// File: rtl/i2c_prim_timer.sv
module i2c_prim_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             at_end_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o    = cnt_q;
   assign at_end_o = (cnt_q == limit_i);

endmodule

// File: rtl/i2c_prim_shifter.sv
module i2c_prim_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] load_val_i,
   input  logic              shift_i,
   input  logic              sin_i,
   output logic              msb_o,
   output logic              next_msb_o,
   output logic [BYTE_W-1:0] data_o
);

   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] sh_d;

   // Shift chain towards the MSB, new sample enters at bit 0.
   for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_chain
      if (gi == 0) begin : g_lsb
         assign sh_d[gi] = sin_i;
      end else begin : g_up
         assign sh_d[gi] = sh_q[gi-1];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sh_q <= '0;
      end else if (load_i) begin
         sh_q <= load_val_i;
      end else if (shift_i) begin
         sh_q <= sh_d;
      end
   end

   assign msb_o      = sh_q[BYTE_W-1];
   assign next_msb_o = sh_q[BYTE_W-2];
   assign data_o     = sh_q;

endmodule

// File: rtl/i2c_prim_engine.sv
module i2c_prim_engine
   import i2c_prim_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int HOLD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [CNT_W-1:0]  scl_high_cnt_i,
   input  logic [CNT_W-1:0]  scl_low_cnt_i,
   input  logic [HOLD_W-1:0] sda_hold_cnt_i,
   input  logic              req_i,
   input  logic [2:0]        op_i,
   input  logic [BYTE_W-1:0] tx_byte_i,
   input  logic              sda_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              ack_bit_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              scl_oe_o,
   output logic              sda_oe_o
);

   localparam int CMP_W  = (CNT_W > HOLD_W) ? CNT_W : HOLD_W;
   localparam int SLOT_W = $clog2(BYTE_W + 1);

   if (CNT_W < 2) begin : g_chk_cnt
      $error("CNT_W must be at least 2");
   end
   if (HOLD_W < 1) begin : g_chk_hold
      $error("HOLD_W must be at least 1");
   end
   if (BYTE_W < 2) begin : g_chk_byte
      $error("BYTE_W must be at least 2");
   end

   prim_phase_e       phase_q;
   prim_op_e          op_q;
   logic [SLOT_W-1:0] slots_q;
   logic              scl_q, sda_q, busy_q, done_q, ack_q;

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  limit;
   logic              at_end, tmr_clr;
   logic              msb, next_msb;

   logic [CMP_W-1:0]  low_x, hold_x, hold_eff;
   logic [CMP_W:0]    cnt_p1;
   logic              hold_hit, hold_zero, mid_hit, accept;
   prim_op_e          req_op, eff_op;

   // Hold delay clamped so that SDA always settles inside the low phase.
   assign low_x     = CMP_W'(scl_low_cnt_i);
   assign hold_x    = CMP_W'(sda_hold_cnt_i);
   assign hold_eff  = (hold_x > low_x) ? low_x : hold_x;
   assign hold_zero = (hold_eff == '0);
   assign cnt_p1    = (CMP_W+1)'(cnt) + (CMP_W+1)'(1);
   assign hold_hit  = (phase_q == PH_LOW) && !hold_zero && (cnt_p1 == {1'b0, hold_eff});
   assign mid_hit   = (phase_q == PH_HIGH) && (cnt == (scl_high_cnt_i >> 1));

   assign req_op  = prim_op_e'(op_i);
   assign eff_op  = ((req_op == OP_START) && scl_q) ? OP_RSTART : req_op;
   assign accept  = enable_i && req_i && !busy_q && (phase_q == PH_IDLE);

   assign limit   = (phase_q == PH_LOW) ? scl_low_cnt_i : scl_high_cnt_i;
   assign tmr_clr = !enable_i || (phase_q == PH_IDLE) || at_end;

   i2c_prim_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (tmr_clr),
      .limit_i  (limit),
      .cnt_o    (cnt),
      .at_end_o (at_end)
   );

   i2c_prim_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (accept),
      .load_val_i (tx_byte_i),
      .shift_i    (mid_hit && enable_i),
      .sin_i      (sda_i),
      .msb_o      (msb),
      .next_msb_o (next_msb),
      .data_o     (rx_byte_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         op_q    <= OP_START;
         slots_q <= '0;
         scl_q   <= 1'b0;
         sda_q   <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         ack_q   <= 1'b0;
      end else if (!enable_i) begin
         phase_q <= PH_IDLE;
         scl_q   <= 1'b0;
         sda_q   <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  busy_q <= 1'b1;
                  op_q   <= eff_op;
                  if (eff_op == OP_START) begin
                     phase_q <= PH_COND;
                     sda_q   <= 1'b1;
                     scl_q   <= 1'b0;
                  end else begin
                     phase_q <= PH_LOW;
                     scl_q   <= 1'b1;
                     slots_q <= is_byte_op(eff_op) ? SLOT_W'(BYTE_W - 1) : '0;
                     if (hold_zero) begin
                        sda_q <= slot_drive(eff_op, tx_byte_i[BYTE_W-1]);
                     end
                  end
               end
            end
            PH_LOW: begin
               if (hold_hit) begin
                  sda_q <= slot_drive(op_q, msb);
               end
               if (at_end) begin
                  phase_q <= PH_HIGH;
                  scl_q   <= 1'b0;
               end
            end
            PH_HIGH: begin
               if (mid_hit && (op_q == OP_GETACK)) begin
                  ack_q <= sda_i;
               end
               if (at_end) begin
                  if (op_q == OP_RSTART) begin
                     phase_q <= PH_COND;
                     sda_q   <= 1'b1;
                  end else if (op_q == OP_STOP) begin
                     phase_q <= PH_FREE;
                     sda_q   <= 1'b0;
                  end else if (slots_q != '0) begin
                     slots_q <= slots_q - SLOT_W'(1);
                     phase_q <= PH_LOW;
                     scl_q   <= 1'b1;
                     if (hold_zero) begin
                        sda_q <= slot_drive(op_q, mid_hit ? next_msb : msb);
                     end
                  end else begin
                     phase_q <= PH_IDLE;
                     scl_q   <= 1'b1;
                     busy_q  <= 1'b0;
                     done_q  <= 1'b1;
                  end
               end
            end
            PH_COND: begin
               if (at_end) begin
                  phase_q <= PH_IDLE;
                  scl_q   <= 1'b1;
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
               end
            end
            PH_FREE: begin
               if (at_end) begin
                  phase_q <= PH_IDLE;
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
               end
            end
            default: begin
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign ack_bit_o = ack_q;
   assign scl_oe_o  = scl_q;
   assign sda_oe_o  = sda_q;

endmodule

// File: rtl/i2c_prim_engine_chk.sv
module i2c_prim_engine_chk #(
   parameter int CNT_W  = 16,
   parameter int HOLD_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              enable_i,
   input logic [CNT_W-1:0]  scl_low_cnt_i,
   input logic [HOLD_W-1:0] sda_hold_cnt_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              scl_oe_o,
   input logic              sda_oe_o
);

   // R11
   disabled_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (!scl_oe_o && !sda_oe_o && !busy_o));

   // R10
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R10
   done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R3
   hold_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && (sda_hold_cnt_i != '0) && (scl_low_cnt_i != '0) && $rose(scl_oe_o))
      |-> $stable(sda_oe_o));

   // R1
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !$past(busy_o) && enable_i && $past(enable_i))
      |-> ($stable(scl_oe_o) && $stable(sda_oe_o)));

   // R7
   start_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(sda_oe_o) && !scl_oe_o && !$past(scl_oe_o)) |-> busy_o);

endmodule

bind i2c_prim_engine i2c_prim_engine_chk #(
   .CNT_W  (CNT_W),
   .HOLD_W (HOLD_W)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .enable_i       (enable_i),
   .scl_low_cnt_i  (scl_low_cnt_i),
   .sda_hold_cnt_i (sda_hold_cnt_i),
   .busy_o         (busy_o),
   .done_o         (done_o),
   .scl_oe_o       (scl_oe_o),
   .sda_oe_o       (sda_oe_o)
);

// File: tb/tb_i2c_prim_engine.sv
module tb_i2c_prim_engine;

   localparam int CW = 6;
   localparam int HW = 6;
   localparam int BW = 8;

   localparam int OPS  = 0;
   localparam int OPR  = 1;
   localparam int OPSP = 2;
   localparam int OPW  = 3;
   localparam int OPRD = 4;
   localparam int OPGA = 5;
   localparam int OPPA = 6;
   localparam int OPPN = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b1;
   logic [CW-1:0] hi_cnt = '0;
   logic [CW-1:0] lo_cnt = '0;
   logic [HW-1:0] hd_cnt = '0;
   logic          req = 1'b0;
   logic [2:0]    op = '0;
   logic [BW-1:0] txb = '0;
   logic          rsp_q = 1'b1;
   logic          sda_in;
   logic          busy, done, ackb, scl_oe, sda_oe;
   logic [BW-1:0] rxb;

   int n_chk = 0;
   int n_fail = 0;
   int L, H, HD;
   bit e_held = 0;
   bit e_sda = 0;

   always #4 clk = ~clk;

   assign sda_in = rsp_q & ~sda_oe;

   i2c_prim_engine #(.CNT_W(CW), .HOLD_W(HW), .BYTE_W(BW)) dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .enable_i       (en),
      .scl_high_cnt_i (hi_cnt),
      .scl_low_cnt_i  (lo_cnt),
      .sda_hold_cnt_i (hd_cnt),
      .req_i          (req),
      .op_i           (op),
      .tx_byte_i      (txb),
      .sda_i          (sda_in),
      .busy_o         (busy),
      .done_o         (done),
      .ack_bit_o      (ackb),
      .rx_byte_o      (rxb),
      .scl_oe_o       (scl_oe),
      .sda_oe_o       (sda_oe)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (high=%0d low=%0d hold=%0d)",
                  tag, act, exp, H, L, HD);
      end
   endtask

   function automatic bit drv_of(input int eop, input logic [7:0] d, input int i);
      case (eop)
         OPW:       return ~d[7-i];
         OPPA, OPSP: return 1'b1;
         default:   return 1'b0;
      endcase
   endfunction

   // Runs one primitive and compares every cycle against a computed timeline.
   task automatic run_op(input int opc, input logic [7:0] d, input logic [7:0] rsp,
                         input bit poke, input string tag);
      int eop, ns, S, he, D, bad_t, act, expv;
      bit has_tail, bad, xs, xd, b;
      eop = (opc == OPS && e_held) ? OPR : opc;
      S  = L + H + 2;
      he = (HD < L) ? HD : L;
      case (eop)
         OPS:       ns = 0;
         OPW, OPRD: ns = 8;
         default:   ns = 1;
      endcase
      has_tail = (eop == OPS) || (eop == OPR) || (eop == OPSP);
      D = ns * S + (has_tail ? H + 1 : 0);
      bad = 0; bad_t = 0; act = 0; expv = 0;
      @(negedge clk);
      req = 1'b1; op = 3'(opc); txb = d;
      @(posedge clk);
      for (int t = 0; t <= D; t++) begin
         @(negedge clk);
         if (t == 0) req = 1'b0;
         if (t == D) begin
            xs = has_tail ? (eop != OPSP) : 1'b1;
            xd = has_tail ? (eop != OPSP) : drv_of(eop, d, ns - 1);
         end else if (t < ns * S) begin
            int i, k;
            i = t / S; k = t % S;
            if (k <= L) begin
               xs = 1'b1;
               if (k >= he) xd = drv_of(eop, d, i);
               else xd = (i == 0) ? e_sda : drv_of(eop, d, i - 1);
            end else begin
               xs = 1'b0;
               xd = drv_of(eop, d, i);
            end
         end else begin
            xs = 1'b0;
            xd = (eop != OPSP);
         end
         if (!bad && ({done, busy, scl_oe, sda_oe} !== {t == D, t != D, xs, xd})) begin
            bad = 1; bad_t = t;
            act  = {done, busy, scl_oe, sda_oe};
            expv = {t == D, t != D, xs, xd};
         end
         if ((eop == OPRD || eop == OPGA) && t < ns * S) begin
            b = (eop == OPRD) ? rsp[7 - t / S] : rsp[0];
            rsp_q = ((t % S) == L + 1 + H / 2) ? b : ~b;
         end else begin
            rsp_q = 1'b1;
         end
         if (poke && t == 2) begin req = 1'b1; op = 3'(OPSP); end
         if (poke && t == 3) req = 1'b0;
      end
      if (bad) $display("  first mismatch at cycle %0d of %0d", bad_t, D);
      chk(!bad, tag, act, expv);
      if (eop == OPRD) chk(rxb === rsp, "R5 received byte", int'(rxb), int'(rsp));
      if (eop == OPGA) chk(ackb === rsp[0], "R6 sampled acknowledge", int'(ackb), int'(rsp[0]));
      e_held = has_tail ? (eop != OPSP) : 1'b1;
      e_sda  = has_tail ? (eop != OPSP) : drv_of(eop, d, ns - 1);
      rsp_q = 1'b1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog: actual no completion expected finish before 200000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int idx;
      bit quiet;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({scl_oe, sda_oe, busy, done} === 4'b0000, "R1 reset state",
          int'({scl_oe, sda_oe, busy, done}), 0);
      quiet = 1;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if ({scl_oe, sda_oe} !== 2'b00) quiet = 0;
      end
      chk(quiet, "R1 idle lines stable", int'(quiet), 1);

      idx = 0;
      for (int h = 0; h <= 4; h++) begin
         for (int l = 0; l <= 4; l++) begin
            for (int hd = 0; hd <= 6; hd++) begin
               logic [7:0] pat, rpat;
               H = h; L = l; HD = hd;
               hi_cnt = CW'(h); lo_cnt = CW'(l); hd_cnt = HW'(hd);
               pat  = 8'hA5 ^ 8'(idx * 37);
               rpat = 8'h3C ^ 8'(idx * 91);
               run_op(OPS,  8'h00, 8'h00, 0, "R7 start from free bus");
               run_op(OPW,  pat,   8'h00, 1, "R2 R3 R4 R10 byte transmit timeline");
               run_op(OPRD, 8'h00, rpat,  0, "R2 R5 byte receive timeline");
               run_op(OPGA, 8'h00, 8'h00, 0, "R6 ack sample timeline");
               run_op(OPPA, 8'h00, 8'h00, 0, "R6 drive ACK timeline");
               run_op(OPPN, 8'h00, 8'h00, 0, "R6 drive NACK timeline");
               run_op(OPR,  8'h00, 8'h00, 0, "R8 repeated start timeline");
               run_op(OPGA, 8'h00, 8'h01, 0, "R6 nack sample timeline");
               run_op(OPS,  8'h00, 8'h00, 0, "R7 start on held bus acts as repeated start");
               run_op(OPSP, 8'h00, 8'h00, 0, "R9 R12 stop timeline");
               idx++;
            end
         end
      end

      // R11 abort by enable, then requests ignored while disabled
      H = 2; L = 3; HD = 1;
      hi_cnt = CW'(H); lo_cnt = CW'(L); hd_cnt = HW'(HD);
      run_op(OPS, 8'h00, 8'h00, 0, "R7 start before abort");
      @(negedge clk);
      req = 1'b1; op = 3'(OPW); txb = 8'h00;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      repeat (4) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk({scl_oe, sda_oe, busy} === 3'b000, "R11 abort releases lines",
          int'({scl_oe, sda_oe, busy}), 0);
      req = 1'b1; op = 3'(OPS);
      quiet = 1;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if ({scl_oe, sda_oe, busy, done} !== 4'b0000) quiet = 0;
      end
      chk(quiet, "R11 request ignored while disabled", int'(quiet), 1);
      req = 1'b0;
      en = 1'b1;
      e_held = 0; e_sda = 0;
      run_op(OPS,  8'h00, 8'h00, 0, "R7 R11 start after re-enable");
      run_op(OPSP, 8'h00, 8'h00, 0, "R9 stop after re-enable");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule